// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block lets a pipelined processor repeat a block of code without spending any branch instructions on it. Software first programs a loop start address, a loop end address and a repeat count through a small register-write port. The block then watches the fetch program counter. Each time the fetch reaches the end address and at least one more pass is due, it redirects the next fetch to the start address and counts the pass down. The loop is armed only while the count is nonzero. There is no separate enable bit.

Around each turnaround, the block also tells the interrupt logic which exceptions may be taken. Normally both interrupts and bus-error exceptions are accepted. In the first execute slot after the loop's last instruction, only a bus error is accepted. In the slot after that, nothing is accepted. After that, both are accepted again.

A rule checker flags instruction placements that would break repeat control. These are PC-relative instructions in forbidden positions, subroutine calls or returns, and branches into the tail of longer loops. The loop length is derived from the two addresses, assuming fixed 2-byte instructions.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, the start address, end address and repeat count are all zero. The mask outputs accept both exception kinds and `rule_viol` is low. While the count is zero, `loop_armed` is low, no redirect is ever produced, and the count stays zero until it is written.
- R2: When `fetch_valid` is high, `fetch_pc` equals the end address, no branch is taken and the count is greater than 1, `redirect` is high in that same cycle. In that cycle `redirect_pc` equals the start address, and the count is one lower after the clock edge.
- R3: A count written as 0 leaves the body to run once. Fetching the end address produces no redirect, and the count stays 0.
- R4: A count written as 1 produces no redirect at the end address, and the count reads 0 after that fetch. A count of N gives exactly N−1 redirects in total.
- R5: A write to the count register in the same cycle as an end-address decrement wins, so the written value is kept.
- R6: A taken branch fetched at the end address suppresses the redirect. If its target is at or below the start address, the count is left unchanged.
- R7: After a redirect, the execute slot in which the end instruction completes still accepts both exception kinds. The next valid execute slot accepts only bus errors (`berr_accept`=1, `irq_accept`=0). The slot after that accepts neither. From the following slot on, both are accepted again. Cycles with `ex_valid` low do not advance this sequence.
- R8: Loop length is L = (end − start)/2 + 1 and position p = (pc − start)/2. For an armed fetch inside the body, `rule_viol` goes high one cycle after a PC-relative instruction in either of two cases: L ≥ 4 and p ≥ L−2, or L ≤ 3 and p ≠ 0.
- R9: For L ≥ 4, an armed fetch inside the body raises `rule_viol` one cycle later in either of two cases. The first is a subroutine call or return. The second is a taken branch whose target is one of the last three body positions (end, end−2 or end−4). For L ≤ 3, neither case is flagged.
- R10: Write-port encoding of `wr_sel`: 0 writes the start address, 1 writes the end address, and 2 writes the count from `wr_data[11:0]`. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 start, 1 end, 2 count) |
| wr_data | input | 32 | Write data |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | 32 | Current fetch program counter |
| fetch_pcrel | input | 1 | Fetched instruction is PC-relative |
| fetch_callret | input | 1 | Fetched instruction is a subroutine call or return |
| branch_taken | input | 1 | Fetched instruction is a taken branch |
| branch_target | input | 32 | Target of that branch |
| ex_valid | input | 1 | An instruction completes execute this cycle |
| ex_pc | input | 32 | Address of that instruction |
| redirect | output | 1 | Override next fetch PC |
| redirect_pc | output | 32 | Next fetch PC when redirecting (loop start) |
| rpt_cnt | output | 12 | Current repeat count |
| loop_armed | output | 1 | Count is nonzero |
| irq_accept | output | 1 | Interrupts may be taken in this execute slot |
| berr_accept | output | 1 | Bus-error exceptions may be taken in this execute slot |
| rule_viol | output | 1 | Placement-rule violation seen on the previous fetch |

## Verification
On every cycle, the assertions check several properties. A redirect appears only at the end address with a count above one, and it always points at the start address. The count drops by exactly one on a redirect unless a write overrides it, and a count of zero holds. The exception mask never accepts interrupts while it refuses bus errors, and it steps through its closed slots in order. Other behaviours can only be shown by the bench's scenarios. These are the total number of passes for counts 0, 1 and N; a branch at the end leaving the count untouched; the slot-by-slot mask sequence after a real turnaround; and the placement rules for each combination of loop length and position.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = 12;
  localparam int INSN_B  = 2;
  localparam int TAIL_N  = 3;

  typedef enum logic [1:0] {
    REG_START = 2'd0,
    REG_END   = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SLOT_OPEN      = 2'd0,
    SLOT_BERR_ONLY = 2'd1,
    SLOT_CLOSED    = 2'd2
  } slot_e;
endpackage

// File: rtl/zol_regs.sv
module zol_regs
  import zol_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          dec_en,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic [CW-1:0] cnt_q
);
  logic [AW-1:0] start_d, end_d;
  logic [CW-1:0] cnt_d;
  logic          start_en, end_en, cnt_en;

  always_comb begin
    start_en = wr_en && (wr_sel == REG_START);
    end_en   = wr_en && (wr_sel == REG_END);
    cnt_en   = dec_en || (wr_en && (wr_sel == REG_COUNT));
    start_d  = wr_data;
    end_d    = wr_data;
    if (wr_en && (wr_sel == REG_COUNT)) cnt_d = wr_data[CW-1:0];
    else                                cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (end_en)   end_q   <= end_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/zol_turn.sv
module zol_turn
  import zol_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          branch_taken,
  input  logic [AW-1:0] branch_target,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] end_q,
  input  logic [CW-1:0] cnt_q,
  output logic          redirect,
  output logic          dec_en
);
  logic at_end, back_branch, more_passes;

  always_comb begin
    at_end      = fetch_valid && (fetch_pc == end_q) && (cnt_q != '0);
    back_branch = branch_taken && (branch_target <= start_q);
    more_passes = (cnt_q > CW'(1));
    dec_en      = at_end && !back_branch;
    redirect    = at_end && !branch_taken && more_passes;
  end
endmodule

// File: rtl/zol_slot.sv
module zol_slot
  import zol_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  input  logic [AW-1:0] end_q,
  output logic          irq_ok,
  output logic          berr_ok
);
  slot_e phase_q, phase_d;
  logic  pend_q, pend_d;
  logic  turn_done;

  always_comb begin
    turn_done = ex_valid && pend_q && (ex_pc == end_q);
    pend_d    = pend_q;
    if (turn_done) pend_d = 1'b0;
    if (redirect)  pend_d = 1'b1;
    phase_d = phase_q;
    if (ex_valid) begin
      unique case (phase_q)
        SLOT_OPEN:      phase_d = turn_done ? SLOT_BERR_ONLY : SLOT_OPEN;
        SLOT_BERR_ONLY: phase_d = SLOT_CLOSED;
        SLOT_CLOSED:    phase_d = SLOT_OPEN;
        default:        phase_d = SLOT_OPEN;
      endcase
    end
    irq_ok  = (phase_q == SLOT_OPEN);
    berr_ok = (phase_q != SLOT_CLOSED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SLOT_OPEN;
      pend_q  <= 1'b0;
    end else begin
      if (ex_valid)          phase_q <= phase_d;
      if (redirect || turn_done) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/zol_rules.sv
module zol_rules
  import zol_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int IBYTES = INSN_B,
  parameter int TAIL   = TAIL_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          fetch_pcrel,
  input  logic          fetch_callret,
  input  logic          branch_taken,
  input  logic [AW-1:0] branch_target,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] end_q,
  output logic          viol_q
);
  localparam int            SH        = $clog2(IBYTES);
  localparam logic [AW-1:0] TAIL_SPAN = AW'((TAIL - 1) * IBYTES);
  localparam logic [AW-1:0] LONG_MIN  = AW'(TAIL + 1);
  localparam logic [AW-1:0] PCREL_GAP = AW'(2);

  logic [AW-1:0] len, pos, tdiff;
  logic          in_body, long_loop, pcrel_bad, tgt_tail, flow_bad, viol_d;

  always_comb begin
    len       = ((end_q - start_q) >> SH) + AW'(1);
    pos       = (fetch_pc - start_q) >> SH;
    tdiff     = end_q - branch_target;
    in_body   = armed && fetch_valid && (fetch_pc >= start_q) && (fetch_pc <= end_q);
    long_loop = (len >= LONG_MIN);
    if (long_loop) pcrel_bad = fetch_pcrel && ((pos + PCREL_GAP) >= len);
    else           pcrel_bad = fetch_pcrel && (pos != '0);
    tgt_tail  = branch_taken && (branch_target >= start_q) &&
                (branch_target <= end_q) && (tdiff <= TAIL_SPAN);
    flow_bad  = long_loop && (fetch_callret || tgt_tail);
    viol_d    = in_body && (pcrel_bad || flow_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int CW      = CNT_W,
  parameter int SYNC_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          fetch_pcrel,
  input  logic          fetch_callret,
  input  logic          branch_taken,
  input  logic [AW-1:0] branch_target,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic [CW-1:0] rpt_cnt,
  output logic          loop_armed,
  output logic          irq_accept,
  output logic          berr_accept,
  output logic          rule_viol
);
  logic [SYNC_N-1:0] rst_sync;
  logic              rst_n_s;
  logic [AW-1:0]     start_q, end_q;
  logic [CW-1:0]     cnt_q;
  logic              dec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync[SYNC_N-1];

  zol_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dec_en(dec_en),
    .start_q(start_q), .end_q(end_q), .cnt_q(cnt_q)
  );

  zol_turn #(.AW(AW), .CW(CW)) u_turn (
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .branch_taken(branch_taken), .branch_target(branch_target),
    .start_q(start_q), .end_q(end_q), .cnt_q(cnt_q),
    .redirect(redirect), .dec_en(dec_en)
  );

  zol_slot #(.AW(AW)) u_slot (
    .clk(clk), .rst_n(rst_n_s), .redirect(redirect),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .end_q(end_q),
    .irq_ok(irq_accept), .berr_ok(berr_accept)
  );

  zol_rules #(.AW(AW)) u_rules (
    .clk(clk), .rst_n(rst_n_s), .armed(loop_armed),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_pcrel(fetch_pcrel), .fetch_callret(fetch_callret),
    .branch_taken(branch_taken), .branch_target(branch_target),
    .start_q(start_q), .end_q(end_q), .viol_q(rule_viol)
  );

  assign redirect_pc = start_q;
  assign rpt_cnt     = cnt_q;
  assign loop_armed  = (cnt_q != '0);
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_pc,
  input logic [AW-1:0] end_q,
  input logic [AW-1:0] start_q,
  input logic          redirect,
  input logic [AW-1:0] redirect_pc,
  input logic [CW-1:0] rpt_cnt,
  input logic          ex_valid,
  input logic          irq_accept,
  input logic          berr_accept
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_sel == 2'd2);

  AST_REDIR_NEEDS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (rpt_cnt > CW'(1)));                                        // R2
  AST_REDIR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (fetch_valid && fetch_pc == end_q));                         // R2
  AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_pc == start_q));                                   // R2
  AST_REDIR_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !cnt_wr) |=> (rpt_cnt == $past(rpt_cnt) - CW'(1)));          // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (rpt_cnt == $past(wr_data[CW-1:0])));                          // R5
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_cnt == '0 && !cnt_wr) |=> (rpt_cnt == '0));                          // R1
  AST_MASK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_accept |-> !irq_accept);                                            // R7
  AST_BERR_SLOT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_accept && berr_accept && ex_valid) |=> !berr_accept);               // R7
  AST_CLOSED_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_accept && ex_valid) |=> (berr_accept && irq_accept));              // R7
endmodule

bind zol_ctrl zol_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .end_q(end_q), .start_q(start_q), .redirect(redirect),
  .redirect_pc(redirect_pc), .rpt_cnt(rpt_cnt), .ex_valid(ex_valid),
  .irq_accept(irq_accept), .berr_accept(berr_accept)
);

// File: tb/zol_ctrl_tb.sv
module zol_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        fetch_valid, fetch_pcrel, fetch_callret, branch_taken, ex_valid;
  logic [31:0] fetch_pc, branch_target, ex_pc;
  logic        redirect, loop_armed, irq_accept, berr_accept, rule_viol;
  logic [31:0] redirect_pc;
  logic [11:0] rpt_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  zol_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_pcrel(fetch_pcrel),
    .fetch_callret(fetch_callret), .branch_taken(branch_taken),
    .branch_target(branch_target), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .redirect(redirect), .redirect_pc(redirect_pc), .rpt_cnt(rpt_cnt),
    .loop_armed(loop_armed), .irq_accept(irq_accept), .berr_accept(berr_accept),
    .rule_viol(rule_viol)
  );

  localparam logic [31:0] BASE = 32'h100;
  localparam int NV = 14;
  // {len[4], pos[4], pcrel, callret, branch, target_pos[4], expected_viol}
  localparam logic [15:0] VEC [NV] = '{
    {4'd4, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    {4'd4, 4'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    {4'd4, 4'd2, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
    {4'd4, 4'd3, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
    {4'd3, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    {4'd3, 4'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
    {4'd1, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    {4'd2, 4'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1},
    {4'd5, 4'd1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1},
    {4'd3, 4'd1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
    {4'd5, 4'd0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1},
    {4'd5, 4'd0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0},
    {4'd6, 4'd5, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0},
    {4'd4, 4'd1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    fetch_valid = 1'b0; fetch_pc = '0; fetch_pcrel = 1'b0; fetch_callret = 1'b0;
    branch_taken = 1'b0; branch_target = '0; ex_valid = 1'b0; ex_pc = '0;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    idle_inputs();
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic fetch_at(input logic [31:0] pc);
    @(negedge clk);
    idle_inputs();
    fetch_valid = 1'b1; fetch_pc = pc;
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cnt", 32'(rpt_cnt), 0);
    check("R1 start", redirect_pc, 0);
    check("R1 armed", 32'(loop_armed), 0);
    check("R1 irq", 32'(irq_accept), 1);
    check("R1 berr", 32'(berr_accept), 1);
    check("R1 viol", 32'(rule_viol), 0);

    // table walk: placement rules R8 / R9
    for (int i = 0; i < NV; i++) begin
      logic [3:0] len, pos, tpos;
      len = VEC[i][15:12]; pos = VEC[i][11:8]; tpos = VEC[i][4:1];
      write_reg(2'd0, BASE);
      write_reg(2'd1, BASE + 32'(2 * (len - 1)));
      write_reg(2'd2, 32'd5);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_pc = BASE + 32'(2 * pos);
      fetch_pcrel = VEC[i][7]; fetch_callret = VEC[i][6];
      branch_taken = VEC[i][5]; branch_target = BASE + 32'(2 * tpos);
      @(negedge clk);
      idle_inputs();
      check(VEC[i][7] ? "R8 pcrel placement" : "R9 flow placement",
            32'(rule_viol), 32'(VEC[i][0]));
    end

    // R1 disarmed: count zero, end fetch gives no redirect
    write_reg(2'd0, BASE);
    write_reg(2'd1, BASE + 32'h6);
    write_reg(2'd2, 32'd0);
    fetch_at(BASE + 32'h6);
    check("R1 no redirect when zero", 32'(redirect), 0);
    check("R3 count 0 falls through", 32'(redirect), 0);
    @(negedge clk);
    check("R3 count stays 0", 32'(rpt_cnt), 0);

    // R2 / R4: count 3 gives two redirects then falls through
    write_reg(2'd2, 32'd3);
    check("R1 armed when nonzero", 32'(loop_armed), 1);
    for (int pass = 0; pass < 3; pass++) begin
      for (int p = 0; p < 4; p++) begin
        fetch_at(BASE + 32'(2 * p));
        if (p == 3) begin
          check("R2 count before end", 32'(rpt_cnt), 32'(3 - pass));
          check("R4 redirect per pass", 32'(redirect), (pass < 2) ? 1 : 0);
          if (pass < 2) check("R2 redirect target", redirect_pc, BASE);
        end
      end
    end
    @(negedge clk);
    idle_inputs();
    check("R4 count 0 after last pass", 32'(rpt_cnt), 0);

    // R4: count 1
    write_reg(2'd2, 32'd1);
    fetch_at(BASE + 32'h6);
    check("R4 count 1 no redirect", 32'(redirect), 0);
    @(negedge clk);
    idle_inputs();
    check("R4 count 1 reaches 0", 32'(rpt_cnt), 0);

    // R5: write beats decrement
    write_reg(2'd2, 32'd3);
    fetch_at(BASE + 32'h6);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd7;
    @(negedge clk);
    idle_inputs();
    check("R5 write wins", 32'(rpt_cnt), 7);

    // R6: backward branch at end
    fetch_at(BASE + 32'h6);
    branch_taken = 1'b1; branch_target = BASE; #1;
    check("R6 branch suppresses redirect", 32'(redirect), 0);
    @(negedge clk);
    idle_inputs();
    check("R6 count unchanged", 32'(rpt_cnt), 7);

    // R10: unused select changes nothing
    write_reg(2'd3, 32'h55);
    check("R10 sel3 count", 32'(rpt_cnt), 7);
    check("R10 sel3 start", redirect_pc, BASE);

    // R7: exception mask around the turnaround
    write_reg(2'd2, 32'd2);
    fetch_at(BASE + 32'h6);
    check("R7 turnaround redirect", 32'(redirect), 1);
    @(negedge clk);
    idle_inputs();
    ex_valid = 1'b1; ex_pc = BASE + 32'h6; #1;
    check("R7 end slot irq", 32'(irq_accept), 1);
    check("R7 end slot berr", 32'(berr_accept), 1);
    @(negedge clk);
    ex_valid = 1'b0; #1;
    check("R7 stall holds berr-only irq", 32'(irq_accept), 0);
    @(negedge clk);
    ex_valid = 1'b1; ex_pc = BASE; #1;
    check("R7 slot1 irq", 32'(irq_accept), 0);
    check("R7 slot1 berr", 32'(berr_accept), 1);
    @(negedge clk);
    ex_pc = BASE + 32'h2; #1;
    check("R7 slot2 irq", 32'(irq_accept), 0);
    check("R7 slot2 berr", 32'(berr_accept), 0);
    @(negedge clk);
    ex_pc = BASE + 32'h4; #1;
    check("R7 slot3 irq", 32'(irq_accept), 1);
    check("R7 slot3 berr", 32'(berr_accept), 1);
    @(negedge clk);
    idle_inputs();

    finish_run();
  end
endmodule